// File: doc/BRIEF.md
# Sector Byte Port Bridge

This block connects an 8-bit processor I/O bus to a storage read engine that delivers one byte per request. The engine is addressed by a sector number and a byte position inside that sector. The processor sets the sector by writing its bytes, one at a time, to a command port. It then polls the status port at the same address. The first poll of an idle channel sends a byte request to the engine, and later polls report whether the byte has arrived. A read of the neighbouring data port returns the byte, withdraws the request and moves the byte position on by one.

No separate start command exists. Every transfer step is a side effect of a bus read, so a driver loop is made of only two kinds of access: poll the status port, then read the data port. Toward the engine, the request and acknowledge lines follow a four-phase handshake. A new request is never raised while the acknowledge of the previous one is still high.

The command/status port sits at `CMD_ADDR` (default 16'hFAD0) and the data port at `CMD_ADDR + 1`.

Top module: `sector_byte_port`

## Requirements
- R1: After reset, `st_sector` is 0, `st_offset` is 0 and `st_begin` is low.
- R2: A write strobe to the command port shifts `st_sector` left by 8 bits and puts `io_wdata` in bits 7:0, so four writes load a 32-bit sector most significant byte first.
- R3: A write strobe to the command port sets `st_offset` to 0 on the following cycle.
- R4: A read strobe to the command port while `st_begin` and `st_ack` are both low makes `st_begin` high on the next cycle; `st_begin` then stays high until a data port read.
- R5: During a command port read, `io_rdata` bit 7 is 1 exactly when `st_begin` and `st_ack` are both high, and bits 6:0 are 0.
- R6: During a data port read, `io_rdata` equals `st_data`, and `st_begin` is low on the next cycle.
- R7: A data port read made while `st_begin` and `st_ack` are both high increments `st_offset` by one; the value 511 wraps to 0 and `st_sector` does not change.
- R8: A command port read while `st_begin` is low and `st_ack` is still high returns 0 and leaves `st_begin` low.
- R9: A data port read made while `st_ack` is low lowers `st_begin` and leaves `st_offset` unchanged.
- R10: A read of any other address, a write to the data port, or a cycle with no strobe leaves sector, offset and request unchanged; `io_rdata` is 0 whenever no port read is being decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Bus address |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the strobe cycle |
| st_sector | output | 32 | Sector number for the engine |
| st_offset | output | 9 | Byte position inside the sector |
| st_begin | output | 1 | Byte request to the engine |
| st_ack | input | 1 | Engine acknowledge, high while `st_data` is valid |
| st_data | input | 8 | Byte from the engine |

## Verification
A table of sectors is loaded and then read in runs of several lengths. One run crosses the end of a sector, which separates correct offset wrapping from a sector that carries over or an offset that saturates. The engine model returns bytes that depend on both sector and offset, so a wrong shift direction or a miscounted offset shows up as a data mismatch and not only as a register mismatch. Directed sequences cover the following cases, each of which would give the same data on a design that ignores the handshake state:
- a poll issued while the previous acknowledge is still high;
- a data read issued before any acknowledge;
- a command write in the middle of a sector;
- accesses to unrelated addresses.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_POLL  = 2'd2,
        ACC_FETCH = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic raise;
        logic drop;
        logic advance;
    } hs_step_t;

    function automatic logic [BYTE_W-1:0] poll_byte(input logic ready);
        return {ready, {(BYTE_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/sbp_decode.sv
module sbp_decode
    import sbp_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]  CMD_ADDR = 16'hFAD0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_kind_e         kind
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = CMD_ADDR + 1'b1;

    always_comb begin
        kind = ACC_IDLE;
        if (wr && addr == CMD_ADDR) begin
            kind = ACC_LOAD;
        end else if (rd && addr == CMD_ADDR) begin
            kind = ACC_POLL;
        end else if (rd && addr == DATA_ADDR) begin
            kind = ACC_FETCH;
        end
    end
endmodule

// File: rtl/sbp_sector_reg.sv
module sbp_sector_reg
    import sbp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [BYTE_W-1:0]       din,
    output logic [LANES*BYTE_W-1:0] sector
);
    logic [BYTE_W-1:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_low
            always_ff @(posedge clk) begin
                if (rst)       lane_q[i] <= '0;
                else if (load) lane_q[i] <= din;
            end
        end else begin : g_up
            always_ff @(posedge clk) begin
                if (rst)       lane_q[i] <= '0;
                else if (load) lane_q[i] <= lane_q[i-1];
            end
        end
        assign sector[i*BYTE_W +: BYTE_W] = lane_q[i];
    end
endmodule

// File: rtl/sbp_offset_ctr.sv
module sbp_offset_ctr #(
    parameter int OFF_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [OFF_W-1:0] offset
);
    always_ff @(posedge clk) begin
        if (rst || clear) offset <= '0;
        else if (advance) offset <= offset + 1'b1;
    end
endmodule

// File: rtl/sbp_handshake.sv
module sbp_handshake
    import sbp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e kind,
    input  logic      ack,
    output logic      req,
    output logic      ready,
    output logic      advance
);
    hs_step_t step;

    always_comb begin
        step.raise   = (kind == ACC_POLL) && !req && !ack;
        step.drop    = (kind == ACC_FETCH);
        step.advance = (kind == ACC_FETCH) && req && ack;
    end

    always_ff @(posedge clk) begin
        if (rst)             req <= 1'b0;
        else if (step.drop)  req <= 1'b0;
        else if (step.raise) req <= 1'b1;
    end

    assign ready   = req & ack;
    assign advance = step.advance;
endmodule

// File: rtl/sector_byte_port.sv
module sector_byte_port
    import sbp_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 16'hFAD0,
    parameter int                LANES    = 4,
    parameter int                OFF_W    = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [BYTE_W-1:0]       io_wdata,
    output logic [BYTE_W-1:0]       io_rdata,
    output logic [LANES*BYTE_W-1:0] st_sector,
    output logic [OFF_W-1:0]        st_offset,
    output logic                    st_begin,
    input  logic                    st_ack,
    input  logic [BYTE_W-1:0]       st_data
);
    acc_kind_e kind;
    logic      ready;
    logic      advance;

    sbp_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_decode (
        .addr (io_addr),
        .wr   (io_wr),
        .rd   (io_rd),
        .kind (kind)
    );

    sbp_sector_reg #(.LANES(LANES)) u_sector (
        .clk    (clk),
        .rst    (rst),
        .load   (kind == ACC_LOAD),
        .din    (io_wdata),
        .sector (st_sector)
    );

    sbp_handshake u_hs (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .ack     (st_ack),
        .req     (st_begin),
        .ready   (ready),
        .advance (advance)
    );

    sbp_offset_ctr #(.OFF_W(OFF_W)) u_offset (
        .clk     (clk),
        .rst     (rst),
        .clear   (kind == ACC_LOAD),
        .advance (advance),
        .offset  (st_offset)
    );

    always_comb begin
        case (kind)
            ACC_POLL:  io_rdata = poll_byte(ready);
            ACC_FETCH: io_rdata = st_data;
            default:   io_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 16'hFAD0,
    parameter int                LANES    = 4,
    parameter int                OFF_W    = 9
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic [LANES*8-1:0]   st_sector,
    input logic [OFF_W-1:0]     st_offset,
    input logic                 st_begin,
    input logic                 st_ack,
    input logic [7:0]           st_data
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = CMD_ADDR + 1'b1;
    localparam int                SW        = LANES * 8;

    logic cmd_wr, cmd_rd, dat_rd;
    assign cmd_wr = io_wr && io_addr == CMD_ADDR;
    assign cmd_rd = io_rd && !io_wr && io_addr == CMD_ADDR;
    assign dat_rd = io_rd && !io_wr && io_addr == DATA_ADDR;

    // R2
    sector_shift_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> st_sector == {$past(st_sector[SW-9:0]), $past(io_wdata)});

    // R3
    offset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> st_offset == '0);

    // R4
    begin_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_begin) |-> $past(cmd_rd));

    // R5
    status_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |-> io_rdata[6:0] == 7'd0);

    // R6
    fetch_drops_begin_chk: assert property (@(posedge clk) disable iff (rst)
        dat_rd |=> !st_begin);

    // R7
    offset_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && st_begin && st_ack) |=>
            (st_offset == $past(st_offset) + 1'b1) && $stable(st_sector));

    // R8
    no_early_begin_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd && !st_begin && st_ack) |=> !st_begin);

    // R9
    offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && !st_ack) |=> $stable(st_offset));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 8'd0);
endmodule

bind sector_byte_port sbp_checker #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .LANES(LANES), .OFF_W(OFF_W)
) u_sbp_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .st_sector(st_sector),
    .st_offset(st_offset), .st_begin(st_begin), .st_ack(st_ack),
    .st_data(st_data)
);

// File: tb/sector_byte_port_bench.sv
module sector_byte_port_bench;
    localparam logic [15:0] CMD  = 16'hFAD0;
    localparam logic [15:0] DAT  = 16'hFAD1;
    localparam int          LAT  = 3;
    localparam int          NVEC = 4;
    // {sector, byte count}
    localparam logic [41:0] VEC_TBL [NVEC] = '{
        {32'h0000_0000, 10'd3},
        {32'h1234_5678, 10'd5},
        {32'hDEAD_BEEF, 10'd514},
        {32'h8000_0001, 10'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [31:0] st_sector;
    logic [8:0]  st_offset;
    logic        st_begin;
    logic        st_ack = 1'b0;
    logic [7:0]  st_data = '0;

    int n_chk = 0, n_bad = 0, resp_cnt = 0;
    logic [31:0] exp_sec;
    logic [8:0]  exp_off;
    bit          done = 0;

    always #5 clk = ~clk;

    sector_byte_port u_sector_byte_port (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .st_sector(st_sector),
        .st_offset(st_offset), .st_begin(st_begin), .st_ack(st_ack),
        .st_data(st_data)
    );

    function automatic logic [7:0] pattern(input logic [31:0] s, input logic [8:0] o);
        return (s[15:8] + o[7:0]) ^ s[31:24] ^ s[7:0] ^ {o[8], s[22:16]};
    endfunction

    // behavioural storage engine, four-phase with LAT-cycle delays
    always @(posedge clk) begin
        if (rst) begin
            st_ack <= 1'b0; resp_cnt <= 0;
        end else if (st_begin != st_ack) begin
            if (resp_cnt == LAT - 1) begin
                resp_cnt <= 0;
                st_ack   <= st_begin;
                if (st_begin) st_data <= pattern(st_sector, st_offset);
            end else begin
                resp_cnt <= resp_cnt + 1;
            end
        end else begin
            resp_cnt <= 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] b);
        @(negedge clk); io_addr = a; io_wr = 1'b1; io_wdata = b;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #2 d = io_rdata;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic wait_ack_low();
        for (int i = 0; i < 20 && st_ack; i++) @(negedge clk);
    endtask

    task automatic load_sector(input logic [31:0] s);
        for (int b = 3; b >= 0; b--) bus_write(CMD, s[b*8 +: 8]);
        exp_sec = s; exp_off = '0;
        check("R2 sector load", st_sector, s);
        check("R3 offset cleared", {23'd0, st_offset}, 32'd0);
    endtask

    task automatic read_one();
        logic [7:0] d;
        bit ok;
        wait_ack_low();
        bus_read(CMD, d);
        check("R4 begin raised by poll", {31'd0, st_begin}, 32'd1);
        ok = 0;
        for (int p = 0; p < 20 && !ok; p++) begin
            bus_read(CMD, d);
            check("R5 status low bits", {25'd0, d[6:0]}, 32'd0);
            ok = d[7];
        end
        check("R5 ready seen", {31'd0, ok}, 32'd1);
        bus_read(DAT, d);
        check("R6 data byte", {24'd0, d}, {24'd0, pattern(exp_sec, exp_off)});
        check("R6 begin lowered", {31'd0, st_begin}, 32'd0);
        exp_off = exp_off + 1'b1;
        check("R7 offset step", {23'd0, st_offset}, {23'd0, exp_off});
        check("R7 sector kept", st_sector, exp_sec);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 sector reset", st_sector, 32'd0);
        check("R1 offset reset", {23'd0, st_offset}, 32'd0);
        check("R1 begin reset", {31'd0, st_begin}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            load_sector(VEC_TBL[v][41:10]);
            for (int k = 0; k < int'(VEC_TBL[v][9:0]); k++) read_one();
        end

        // R8: poll while previous acknowledge still high
        load_sector(32'hCAFE_0042);
        read_one();
        bus_read(CMD, d);
        check("R8 closing poll data", {24'd0, d}, 32'd0);
        check("R8 begin kept low", {31'd0, st_begin}, 32'd0);
        read_one();

        // R9: data read before acknowledge
        wait_ack_low();
        bus_read(CMD, d);
        bus_read(DAT, d);
        check("R9 begin lowered", {31'd0, st_begin}, 32'd0);
        check("R9 offset held", {23'd0, st_offset}, {23'd0, exp_off});
        repeat (LAT + 3) @(negedge clk);
        check("R9 no late request", {31'd0, st_begin}, 32'd0);
        read_one();

        // R2/R3: write in mid-sector
        bus_write(CMD, 8'h9C);
        exp_sec = {exp_sec[23:0], 8'h9C}; exp_off = '0;
        check("R2 mid shift", st_sector, exp_sec);
        check("R3 mid clear", {23'd0, st_offset}, 32'd0);
        read_one();

        // R10: unrelated accesses
        wait_ack_low();
        bus_read(16'hFAD2, d);
        check("R10 other read data", {24'd0, d}, 32'd0);
        check("R10 begin unchanged", {31'd0, st_begin}, 32'd0);
        bus_write(DAT, 8'h77);
        bus_write(16'h00D0, 8'h55);
        check("R10 sector unchanged", st_sector, exp_sec);
        check("R10 offset unchanged", {23'd0, st_offset}, {23'd0, exp_off});
        #2 check("R10 idle rdata", {24'd0, io_rdata}, 32'd0);

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 sector re-reset", st_sector, 32'd0);
        check("R1 offset re-reset", {23'd0, st_offset}, 32'd0);
        check("R1 begin re-reset", {31'd0, st_begin}, 32'd0);

        finish_run();
    end
endmodule